// File: doc/BRIEF.md
# Adaptive Green Time Allocator

This block decides how long each direction of a single-lane, two-way road segment keeps its green lamp. A fixed green budget of `BUDGET` ticks per full signal cycle is shared between the two directions. The block keeps the direction-1 share as a tick count. The direction-2 share is always what remains of the budget. Once per sampling window, an external flow counter presents a signed difference between direction-1 and direction-2 traffic. The direction-1 share then moves by one tick toward the busier direction. It never leaves a fixed band, so neither direction can be starved.

The block also contains the single green timer that ends both green phases. The lamp sequencer drives the two green lamp states into the block, together with a one-cycle tick strobe that marks the basic time unit. The timer advances once per tick while a green lamp is lit and pauses while both greens are off. The block raises the direction-1 end flag when the timer meets the direction-1 share. It raises the direction-2 end flag when the timer reaches the last count. Once the direction-2 green has been switched off, the timer returns to zero, ready for the next direction-1 green.

Top module: `green_split_alloc`

## Requirements
- R1: While reset is asserted, and after it is released, the direction-1 share is 7, the direction-2 share is 9, the timer is 0 and both end flags are low.
- R2: On a window strobe with a positive flow difference, the direction-1 share rises by one tick. With a negative difference it falls by one tick. With a zero difference it is left unchanged. The new value appears in the cycle after the strobe.
- R3: The direction-1 share never rises above 12 and never falls below 3. A strobe that would move it past either limit leaves it unchanged.
- R4: The direction-2 share output always equals 16 minus the direction-1 share.
- R5: On each tick with a green lamp lit, the timer rises by one. When no tick arrives, or when both greens are off, the timer keeps its value.
- R6: The direction-1 end flag is high exactly when green 1 is lit and the timer equals the direction-1 share. While that condition holds, further ticks leave the timer unchanged.
- R7: The direction-2 end flag is high exactly when green 2 is lit and the timer equals 15. Ticks arriving at that count leave the timer at 15.
- R8: In the cycle after green 2 goes from lit to unlit, the timer reads 0.
- R9: The direction-1 share does not change in any cycle without a window strobe, whatever the flow difference input holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle strobe marking one time unit |
| window_i | input | 1 | One-cycle strobe at the end of a sampling window |
| flow_diff_i | input | 5 | Signed direction-1 minus direction-2 traffic count, read at window strobes |
| green1_i | input | 1 | Green lamp of direction 1 is lit |
| green2_i | input | 1 | Green lamp of direction 2 is lit |
| t1_share_o | output | 4 | Direction-1 green share in ticks |
| t2_share_o | output | 4 | Direction-2 green share in ticks |
| timer_o | output | 4 | Current green timer count |
| t1_end_o | output | 1 | Direction-1 green has run its share |
| t2_end_o | output | 1 | Direction-2 green has reached the last count |

## Verification
The hardest behaviour to reach from the ports is the pair of saturation limits. Reaching the upper limit takes five consecutive positive windows, and reaching the lower limit takes nine negative ones, with extra strobes pushed beyond each limit. The bench drives long trains of window strobes with the sign held, then reverses the sign to walk the share back to its start value. A second hard case is the pause and hold behaviour of the timer. Here the bench keeps sending ticks after each end flag rises and while both greens are off, and checks that the count stays frozen until green 2 lights.

// File: rtl/gta_pkg.sv
package gta_pkg;
  typedef enum logic [1:0] {
    ADJ_HOLD = 2'd0,
    ADJ_UP   = 2'd1,
    ADJ_DOWN = 2'd2
  } adj_e;
endpackage

// File: rtl/gta_reset_sync.sv
module gta_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gta_flow_decode.sv
module gta_flow_decode
  import gta_pkg::*;
#(
  parameter int DIFF_W = 5
) (
  input  logic              window_i,
  input  logic [DIFF_W-1:0] flow_diff_i,
  output adj_e              adj_o
);
  logic negative;
  logic nonzero;

  assign negative = flow_diff_i[DIFF_W-1];
  assign nonzero  = |flow_diff_i;

  always_comb begin
    adj_o = ADJ_HOLD;
    if (window_i && nonzero) adj_o = negative ? ADJ_DOWN : ADJ_UP;
  end
endmodule

// File: rtl/gta_split_reg.sv
module gta_split_reg
  import gta_pkg::*;
#(
  parameter int TW     = 4,
  parameter int T1_INIT = 7,
  parameter int T1_MIN  = 3,
  parameter int T1_MAX  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  adj_e          adj_i,
  output logic [TW-1:0] share_o
);
  localparam logic [TW-1:0] INIT_V = TW'(T1_INIT);
  localparam logic [TW-1:0] MIN_V  = TW'(T1_MIN);
  localparam logic [TW-1:0] MAX_V  = TW'(T1_MAX);

  logic [TW-1:0] share_q, share_d;
  logic          share_en;

  always_comb begin
    share_en = 1'b0;
    share_d  = share_q;
    unique case (adj_i)
      ADJ_UP: if (share_q != MAX_V) begin
        share_en = 1'b1;
        share_d  = share_q + 1'b1;
      end
      ADJ_DOWN: if (share_q != MIN_V) begin
        share_en = 1'b1;
        share_d  = share_q - 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        share_q <= INIT_V;
    else if (share_en) share_q <= share_d;
  end

  assign share_o = share_q;
endmodule

// File: rtl/gta_green_timer.sv
module gta_green_timer #(
  parameter int TW     = 4,
  parameter int BUDGET = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          green1_i,
  input  logic          green2_i,
  input  logic [TW-1:0] share1_i,
  output logic [TW-1:0] count_o,
  output logic          end1_o,
  output logic          end2_o
);
  localparam logic [TW-1:0] LAST = TW'(BUDGET - 1);

  logic [TW-1:0] count_q, count_d;
  logic          count_en;
  logic          g2_q;
  logic          g2_off;
  logic          at_share;
  logic          at_last;

  assign at_share = (count_q == share1_i);
  assign at_last  = (count_q == LAST);
  assign g2_off   = g2_q & ~green2_i;

  always_comb begin
    count_en = 1'b0;
    count_d  = count_q;
    if (g2_off) begin
      count_en = 1'b1;
      count_d  = '0;
    end else if (tick_i && !at_last &&
                 ((green1_i && !at_share) || green2_i)) begin
      count_en = 1'b1;
      count_d  = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) g2_q <= 1'b0;
    else        g2_q <= green2_i;
  end

  assign count_o = count_q;
  assign end1_o  = green1_i & at_share;
  assign end2_o  = green2_i & at_last;
endmodule

// File: rtl/green_split_alloc.sv
module green_split_alloc
  import gta_pkg::*;
#(
  parameter int BUDGET  = 16,
  parameter int T1_INIT = 7,
  parameter int T1_MIN  = 3,
  parameter int T1_MAX  = 12,
  parameter int DIFF_W  = 5,
  localparam int TW     = $clog2(BUDGET)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              window_i,
  input  logic [DIFF_W-1:0] flow_diff_i,
  input  logic              green1_i,
  input  logic              green2_i,
  output logic [TW-1:0]     t1_share_o,
  output logic [TW-1:0]     t2_share_o,
  output logic [TW-1:0]     timer_o,
  output logic              t1_end_o,
  output logic              t2_end_o
);
  logic rst_int_n;
  adj_e adj;

  gta_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  gta_flow_decode #(.DIFF_W(DIFF_W)) u_dec (
    .window_i    (window_i),
    .flow_diff_i (flow_diff_i),
    .adj_o       (adj)
  );

  gta_split_reg #(
    .TW(TW), .T1_INIT(T1_INIT), .T1_MIN(T1_MIN), .T1_MAX(T1_MAX)
  ) u_split (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .adj_i   (adj),
    .share_o (t1_share_o)
  );

  gta_green_timer #(.TW(TW), .BUDGET(BUDGET)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick_i   (tick_i),
    .green1_i (green1_i),
    .green2_i (green2_i),
    .share1_i (t1_share_o),
    .count_o  (timer_o),
    .end1_o   (t1_end_o),
    .end2_o   (t2_end_o)
  );

  assign t2_share_o = TW'(BUDGET - int'(t1_share_o));
endmodule

// File: rtl/green_split_alloc_chk.sv
module green_split_alloc_chk #(
  parameter int TW     = 4,
  parameter int T1_MIN = 3,
  parameter int T1_MAX = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          window_i,
  input logic          green1_i,
  input logic          green2_i,
  input logic [TW-1:0] t1_share_o,
  input logic [TW-1:0] timer_o,
  input logic          t1_end_o,
  input logic          t2_end_o
);
  a_r3_share_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_share_o >= TW'(T1_MIN)) && (t1_share_o <= TW'(T1_MAX)));

  a_r9_share_moves_on_window: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_share_o != $past(t1_share_o)) |-> $past(window_i));

  a_r5_idle_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!green1_i && !green2_i && !$past(green2_i)) |=> $stable(timer_o));

  a_r6_hold_at_share: assert property (@(posedge clk) disable iff (!rst_n)
    t1_end_o |=> ($stable(timer_o) || green2_i));

  a_r7_hold_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    t2_end_o |=> $stable(timer_o));

  a_r8_clear_after_g2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(green2_i) && !green2_i) |=> (timer_o == '0));
endmodule

bind green_split_alloc green_split_alloc_chk #(
  .TW(TW), .T1_MIN(T1_MIN), .T1_MAX(T1_MAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .window_i   (window_i),
  .green1_i   (green1_i),
  .green2_i   (green2_i),
  .t1_share_o (t1_share_o),
  .timer_o    (timer_o),
  .t1_end_o   (t1_end_o),
  .t2_end_o   (t2_end_o)
);

// File: tb/green_split_alloc_test.sv
module green_split_alloc_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i;
  logic       window_i;
  logic [4:0] flow_diff_i;
  logic       green1_i;
  logic       green2_i;
  logic [3:0] t1_share_o;
  logic [3:0] t2_share_o;
  logic [3:0] timer_o;
  logic       t1_end_o;
  logic       t2_end_o;

  int checks = 0;
  int errors = 0;
  int exp_share = 7;

  always #2 clk = ~clk;

  green_split_alloc uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .window_i(window_i),
    .flow_diff_i(flow_diff_i), .green1_i(green1_i), .green2_i(green2_i),
    .t1_share_o(t1_share_o), .t2_share_o(t2_share_o), .timer_o(timer_o),
    .t1_end_o(t1_end_o), .t2_end_o(t2_end_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic window_step(input int diff);
    window_i    = 1'b1;
    flow_diff_i = 5'(diff);
    @(negedge clk);
    window_i = 1'b0;
    if (diff > 0 && exp_share < 12) exp_share++;
    else if (diff < 0 && exp_share > 3) exp_share--;
  endtask

  task automatic tick_once();
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick_i = 1'b0; window_i = 1'b0; flow_diff_i = '0;
    green1_i = 1'b0; green2_i = 1'b0;
    idle(3);
    chk_eq("R1 share1 in reset", int'(t1_share_o), 7);
    chk_eq("R1 share2 in reset", int'(t2_share_o), 9);
    chk_eq("R1 timer in reset", int'(timer_o), 0);
    rst_n = 1'b1;
    idle(4);
    chk_eq("R1 share1 after reset", int'(t1_share_o), 7);
    chk_eq("R1 flags after reset", int'({t1_end_o, t2_end_o}), 0);
  endtask

  task automatic t_adjust();
    window_step(5);
    chk_eq("R2 up step", int'(t1_share_o), 8);
    chk_eq("R4 share2 after up", int'(t2_share_o), 8);
    window_step(-3);
    chk_eq("R2 down step", int'(t1_share_o), 7);
    window_step(0);
    chk_eq("R2 zero holds", int'(t1_share_o), 7);
    flow_diff_i = 5'(9);
    idle(5);
    chk_eq("R9 no window no change", int'(t1_share_o), 7);
    window_step(-16);
    chk_eq("R2 most negative", int'(t1_share_o), 6);
    window_step(15);
    chk_eq("R2 most positive", int'(t1_share_o), 7);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 9; i++) window_step(1);
    chk_eq("R3 upper limit", int'(t1_share_o), 12);
    chk_eq("R4 share2 at upper", int'(t2_share_o), 4);
    for (int i = 0; i < 14; i++) window_step(-2);
    chk_eq("R3 lower limit", int'(t1_share_o), 3);
    chk_eq("R4 share2 at lower", int'(t2_share_o), 13);
    for (int i = 0; i < 4; i++) window_step(3);
    chk_eq("R2 walk back", int'(t1_share_o), exp_share);
  endtask

  task automatic t_phase();
    green1_i = 1'b1;
    idle(1);
    chk_eq("R6 no end at zero", int'(t1_end_o), 0);
    idle(3);
    chk_eq("R5 no tick holds", int'(timer_o), 0);
    for (int i = 1; i <= exp_share; i++) begin
      tick_once();
      chk_eq("R5 timer step green1", int'(timer_o), i);
      chk_eq("R6 end1 flag", int'(t1_end_o), (i == exp_share) ? 1 : 0);
    end
    tick_once(); tick_once();
    chk_eq("R6 hold at share", int'(timer_o), exp_share);
    green1_i = 1'b0;
    idle(1);
    chk_eq("R6 end1 drops with green1", int'(t1_end_o), 0);
    tick_once(); tick_once(); tick_once();
    chk_eq("R5 paused between greens", int'(timer_o), exp_share);
    green2_i = 1'b1;
    for (int i = exp_share + 1; i <= 15; i++) begin
      tick_once();
      chk_eq("R5 timer step green2", int'(timer_o), i);
      chk_eq("R7 end2 flag", int'(t2_end_o), (i == 15) ? 1 : 0);
    end
    tick_once(); tick_once();
    chk_eq("R7 hold at last", int'(timer_o), 15);
    chk_eq("R7 end2 stays", int'(t2_end_o), 1);
    green2_i = 1'b0;
    idle(1);
    chk_eq("R8 cleared after green2 off", int'(timer_o), 0);
    chk_eq("R7 end2 low", int'(t2_end_o), 0);
  endtask

  task automatic t_mid_adjust();
    green1_i = 1'b1;
    tick_once(); tick_once(); tick_once();
    chk_eq("R5 restart from zero", int'(timer_o), 3);
    window_step(-1);
    chk_eq("R2 down during green", int'(t1_share_o), exp_share);
    green1_i = 1'b0;
    green2_i = 1'b1;
    tick_once();
    green2_i = 1'b0;
    idle(1);
    chk_eq("R8 clear after short green2", int'(timer_o), 0);
  endtask

  initial begin
    t_reset();
    t_adjust();
    t_saturate();
    t_phase();
    t_mid_adjust();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule